// File: doc/BRIEF.md
# Label-offset program counter unit

This unit keeps the program counter of a small in-order core as two fields: a label index and an instruction offset counted from that label. A shadow copy of the counter sits beside it. The counter is turned into an absolute instruction fetch address through a small label table. The table maps each label index to the instruction address it stands for. Labels occupy no instruction memory, so each entry holds the address of the first real instruction after the label.

The table is filled while the core is held in reset. After reset the counter advances by one instruction on each sequential-advance strobe. A taken redirect instead rewrites the counter fields, and each of the four redirect kinds has its own rule for doing so. On every advance or redirect, the shadow copy keeps the counter value from before the update, so a linking branch can save its return position. Decoding and branch-condition evaluation are done outside the unit. The caller presents only the redirect kind, its operands and a taken flag.

Top module: `lbl_pc`

## Requirements
- R1: `fetch_addr` always equals the table address for the current label plus the offset field, modulo 2^ADDR_W.
- R2: With `adv` high and `redir_taken` low, the offset rises by one (modulo 2^OFS_W) on the clock edge and the label is unchanged.
- R3: A taken redirect of kind 2'b00 (relative branch) adds the two's-complement `redir_imm` to the offset, modulo 2^OFS_W, and keeps the label.
- R4: A taken redirect of kind 2'b01 (label branch) or 2'b11 (label jump) loads `redir_lbl` into the label field and clears the offset to zero.
- R5: A taken redirect of kind 2'b10 (immediate jump) sets the label to 0, which is the entry-point label, and loads `redir_imm` into the offset.
- R6: While `rst_n` is low, the counter and the shadow copy both read label 0 with offset 0, and `fetch_addr` reads 0.
- R7: On every edge where `adv` or `redir_taken` is high, the shadow copy takes the counter value from before the edge. Otherwise it holds.
- R8: With both `adv` and `redir_taken` low, the counter is unchanged.
- R9: Table writes take effect only while `rst_n` is low. Label 0 always maps to address 0, and a write to index 0 is ignored.
- R10: When `redir_taken` and `adv` are both high, the redirect rule applies and no increment is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the table is loaded while low |
| tbl_we | input | 1 | Label table write enable |
| tbl_idx | input | LBL_W | Label table write index |
| tbl_data | input | ADDR_W | Absolute instruction address for the label |
| adv | input | 1 | Sequential advance strobe |
| redir_taken | input | 1 | Apply the redirect this cycle |
| redir_kind | input | 2 | 00 relative branch, 01 label branch, 10 immediate jump, 11 label jump |
| redir_lbl | input | LBL_W | Label operand |
| redir_imm | input | OFS_W | Integer operand (two's complement for branches) |
| pc_lbl | output | LBL_W | Current label field |
| pc_ofs | output | OFS_W | Current offset field |
| fetch_addr | output | ADDR_W | Resolved absolute fetch address |
| sh_lbl | output | LBL_W | Shadow label field |
| sh_ofs | output | OFS_W | Shadow offset field |

## Verification
The bench loads all sixteen table entries with distinct computed addresses. It then jumps to every label using both label redirect kinds and advances several times after each jump. This separates a wrong table index from a wrong offset add. Relative branches are swept over positive, negative and wrapping operands, and immediate jumps over the full offset range including 255. These sweeps show whether the operand is added or loaded, and whether the label is kept or forced to 0. Idle cycles, simultaneous advance and redirect, writes to the table after reset, a write to index 0, and a reset in mid-run check the hold, priority, table-protection and reset rules. The shadow copy is compared after every step.

// File: rtl/lbl_pc.sv
module lbl_pc #(
  parameter int LBL_W  = 4,
  parameter int OFS_W  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [LBL_W-1:0]  tbl_idx,
  input  logic [ADDR_W-1:0] tbl_data,
  input  logic              adv,
  input  logic              redir_taken,
  input  logic [1:0]        redir_kind,
  input  logic [LBL_W-1:0]  redir_lbl,
  input  logic [OFS_W-1:0]  redir_imm,
  output logic [LBL_W-1:0]  pc_lbl,
  output logic [OFS_W-1:0]  pc_ofs,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [LBL_W-1:0]  sh_lbl,
  output logic [OFS_W-1:0]  sh_ofs
);
  localparam int NLBL = 1 << LBL_W;
  localparam logic [1:0] K_REL  = 2'b00;
  localparam logic [1:0] K_JIMM = 2'b10;

  logic [ADDR_W-1:0] tbl [NLBL];
  logic [LBL_W-1:0]  nxt_lbl;
  logic [OFS_W-1:0]  nxt_ofs;
  logic              moving;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl[0] <= '0;
      if (tbl_we && tbl_idx != '0) tbl[tbl_idx] <= tbl_data;
    end
  end

  assign fetch_addr = tbl[pc_lbl] + ADDR_W'(pc_ofs);
  assign moving     = redir_taken | adv;

  always_comb begin
    nxt_lbl = pc_lbl;
    nxt_ofs = pc_ofs;
    if (redir_taken) begin
      case (redir_kind)
        K_REL:   nxt_ofs = pc_ofs + redir_imm;
        K_JIMM:  begin nxt_lbl = '0; nxt_ofs = redir_imm; end
        default: begin nxt_lbl = redir_lbl; nxt_ofs = '0; end
      endcase
    end else if (adv) begin
      nxt_ofs = pc_ofs + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_lbl <= '0;
      pc_ofs <= '0;
      sh_lbl <= '0;
      sh_ofs <= '0;
    end else if (moving) begin
      pc_lbl <= nxt_lbl;
      pc_ofs <= nxt_ofs;
      sh_lbl <= pc_lbl;
      sh_ofs <= pc_ofs;
    end
  end
endmodule

module lbl_pc_chk #(
  parameter int LBL_W  = 4,
  parameter int OFS_W  = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv,
  input logic              redir_taken,
  input logic [1:0]        redir_kind,
  input logic [LBL_W-1:0]  redir_lbl,
  input logic [OFS_W-1:0]  redir_imm,
  input logic [LBL_W-1:0]  pc_lbl,
  input logic [OFS_W-1:0]  pc_ofs,
  input logic [LBL_W-1:0]  sh_lbl,
  input logic [OFS_W-1:0]  sh_ofs
);
  a_r6_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (pc_lbl == '0 && pc_ofs == '0 && sh_lbl == '0 && sh_ofs == '0));

  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !redir_taken) |=> (pc_ofs == OFS_W'($past(pc_ofs) + 1'b1) && $stable(pc_lbl)));

  a_r3_rel_add: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_taken && redir_kind == 2'b00)
      |=> (pc_ofs == OFS_W'($past(pc_ofs) + $past(redir_imm)) && $stable(pc_lbl)));

  a_r4_label_load: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_taken && redir_kind[0]) |=> (pc_lbl == $past(redir_lbl) && pc_ofs == '0));

  a_r5_jump_imm: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_taken && redir_kind == 2'b10) |=> (pc_lbl == '0 && pc_ofs == $past(redir_imm)));

  a_r7_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (adv || redir_taken) |=> (sh_lbl == $past(pc_lbl) && sh_ofs == $past(pc_ofs)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !redir_taken) |=> ($stable(pc_lbl) && $stable(pc_ofs) && $stable(sh_ofs)));
endmodule

bind lbl_pc lbl_pc_chk #(.LBL_W(LBL_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adv(adv), .redir_taken(redir_taken),
  .redir_kind(redir_kind), .redir_lbl(redir_lbl), .redir_imm(redir_imm),
  .pc_lbl(pc_lbl), .pc_ofs(pc_ofs), .sh_lbl(sh_lbl), .sh_ofs(sh_ofs));

// File: tb/lbl_pc_tb.sv
module lbl_pc_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tbl_we = 0;
  logic [3:0] tbl_idx = 0;
  logic [7:0] tbl_data = 0;
  logic       adv = 0;
  logic       redir_taken = 0;
  logic [1:0] redir_kind = 0;
  logic [3:0] redir_lbl = 0;
  logic [7:0] redir_imm = 0;
  logic [3:0] pc_lbl, sh_lbl;
  logic [7:0] pc_ofs, sh_ofs, fetch_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0] tm [16];
  logic [3:0] e_lbl = 0, e_slbl = 0;
  logic [7:0] e_ofs = 0, e_sofs = 0;

  always #4 clk = ~clk;

  lbl_pc u_dut (.*);

  initial begin
    #1000000;
    $display("FAIL watchdog expired");
    errors++;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " label"}, pc_lbl, e_lbl);
    chk({tag, " offset"}, pc_ofs, e_ofs);
    chk({"R1 ", tag, " fetch"}, fetch_addr, 8'(tm[e_lbl] + e_ofs));
    chk({"R7 ", tag, " shadow label"}, sh_lbl, e_slbl);
    chk({"R7 ", tag, " shadow offset"}, sh_ofs, e_sofs);
  endtask

  task automatic cyc(input logic a, input logic t, input logic [1:0] k,
                     input logic [3:0] l, input logic [7:0] im, input string tag);
    adv = a; redir_taken = t; redir_kind = k; redir_lbl = l; redir_imm = im;
    @(posedge clk); #2;
    adv = 0; redir_taken = 0;
    if (a || t) begin
      e_slbl = e_lbl; e_sofs = e_ofs;
      if (t) begin
        case (k)
          2'b00: e_ofs = e_ofs + im;
          2'b10: begin e_lbl = 0; e_ofs = im; end
          default: begin e_lbl = l; e_ofs = 0; end
        endcase
      end else e_ofs = e_ofs + 1;
    end
    chk_all(tag);
  endtask

  initial begin
    tm[0] = 0;
    for (int i = 1; i < 16; i++) tm[i] = 8'(i * 13 + 5);
    @(posedge clk); #2;
    for (int i = 0; i < 16; i++) begin
      tbl_we = 1; tbl_idx = 4'(i); tbl_data = (i == 0) ? 8'hAA : tm[i];
      @(posedge clk); #2;
    end
    tbl_we = 0;
    chk_all("R6 reset");
    chk("R6 reset fetch", fetch_addr, 0);
    rst_n = 1;
    @(posedge clk); #2;
    chk_all("R8 idle after reset");

    for (int l = 0; l < 16; l++) begin
      cyc(0, 1, (l % 2 == 0) ? 2'b11 : 2'b01, 4'(l), 8'd77, "R4 label redirect");
      for (int s = 0; s < 3; s++) cyc(1, 0, 2'b00, 0, 0, "R2 advance");
    end

    cyc(0, 1, 2'b11, 4'd5, 0, "R4 jump to 5");
    for (int d = -6; d <= 6; d += 3)
      cyc(0, 1, 2'b00, 4'd9, 8'(d), "R3 relative branch");
    cyc(0, 1, 2'b00, 0, 8'd250, "R3 relative wrap");

    for (int v = 0; v < 256; v += 51)
      cyc(0, 1, 2'b10, 4'd7, 8'(v), "R5 immediate jump");
    cyc(0, 1, 2'b10, 0, 8'd255, "R5 immediate jump top");
    cyc(1, 0, 2'b00, 0, 0, "R2 offset wrap");

    cyc(0, 0, 2'b11, 4'd3, 8'd9, "R8 hold");
    cyc(0, 0, 2'b00, 4'd3, 8'd9, "R8 hold again");
    cyc(1, 1, 2'b11, 4'd12, 0, "R10 redirect over advance");
    cyc(1, 1, 2'b00, 0, 8'd4, "R10 relative over advance");

    tbl_we = 1; tbl_idx = 4'd2; tbl_data = 8'hEE;
    @(posedge clk); #2;
    tbl_we = 0;
    chk_all("R9 write after reset no counter effect");
    cyc(0, 1, 2'b01, 4'd2, 0, "R9 entry 2 unchanged");
    cyc(0, 1, 2'b10, 0, 0, "R9 entry 0 fixed at 0");
    chk("R9 entry 0 fetch", fetch_addr, 0);

    cyc(0, 1, 2'b11, 4'd14, 0, "R4 before reset");
    cyc(1, 0, 2'b00, 0, 0, "R2 before reset");
    rst_n = 0;
    @(posedge clk); #2;
    e_lbl = 0; e_ofs = 0; e_slbl = 0; e_sofs = 0;
    chk_all("R6 mid-run reset");
    rst_n = 1;
    cyc(1, 0, 2'b00, 0, 0, "R2 after second reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule